// File: doc/BRIEF.md
# Write-Once Usage Time Recorder

This block keeps a tamper-resistant count of how long a chip has been powered. A prescaler turns the fast system clock into a slow tick, and a session counter counts those ticks. The session counter starts from zero at every power-up. An adder puts the session count on top of the total recovered at power-up. Each time the sum grows, the cell of a write-once bit array whose address equals the new total is set. The total is therefore the highest set address in the array. Because cells can only be set, the record survives power cycles and cannot be wound back.

After every reset the block first reads the array with a binary search over the address bits. This costs one read per address bit and finds the highest set cell. It relies on the set cells forming one unbroken run from address 0, and address 0 always counts as set. Only after the search may the recorder program cells. While the authentication input is high, the array stays in read mode and the committed total is driven, zero-extended, onto the functional output pins in place of the normal data. Cells missed during that window are filled in, one per clock, once the input falls. The total saturates at the last address and raises a full flag. The array is a behavioural model with cells that can only be set; charge pumps and programming voltages are not modelled. The intended system clock is 24 MHz.

Top module: `usage_recorder`

## Requirements
- R1: After reset on a blank array the total shown with `auth` high is 0 and `full` is low.
- R2: With `auth` low, `pin_out` equals `func_in` in the same cycle. With `auth` high, `pin_out` shows the committed total, zero-extended to `OUT_W` bits.
- R3: Once the power-up search is done, the total grows by exactly one for every `DIV_RATIO` system clocks. Each increase shows on `pin_out` two clocks after the tick.
- R4: Every increase of the total sets the array cell whose address is the new total. After a reset the recovered total equals the total before the reset.
- R5: The power-up search takes `ADDR_W` clocks. The shown total is 0 until the edge `ADDR_W`+1 clocks after reset release, and at that edge it becomes the recovered total. No cell is programmed before the search ends.
- R6: While `auth` is high no cell is programmed and the shown total stays frozen. After `auth` falls, the missed cells are programmed one per clock in increasing order, so the next recovered total includes every tick counted during the hold.
- R7: The total saturates at 2^`ADDR_W`-1. `full` goes high when the committed total reaches that value, stays high, and is high again right after the next power-up.
- R8: After a reset the session count restarts from zero and adds to the recovered total, so counting continues from the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| auth | input | 1 | Authentication mode: hold array in read mode and show the total |
| func_in | input | OUT_W | Normal functional output data |
| pin_out | output | OUT_W | Shared output pins: func_in, or the zero-extended total |
| full | output | 1 | Total has reached the last array address |

## Verification
The critical overlap is a tick-driven program request arriving while `auth` is high. The program step must wait, yet the cells it would have set must still be written later, so that the run of set cells stays unbroken. The bench holds `auth` high across three ticks, checks that the shown total does not move, and releases it. It then checks that the total catches up. A reset follows, and the total recovered by the binary search must include all three held-back ticks; a gap in the run would make the search stop early. A second overlap, the first tick against the end of the search, is judged by sampling the total exactly at and one clock before the edge where the recovered value must appear.

// File: rtl/usage_rec_pkg.sv
package usage_rec_pkg;

    typedef enum logic [1:0] {
        SRCH_IDLE = 2'd0,
        SRCH_WALK = 2'd1,
        SRCH_DONE = 2'd2
    } srch_state_e;

    typedef struct packed {
        logic armed;   // committed registers loaded with the recovered total
        logic differ;  // sampled sum and committed total disagree
        logic prog;    // program strobe toward the array
    } commit_ctl_t;

    // Saturating sum of two counts, limited to lim.
    function automatic int unsigned sat_sum(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned lim);
        int unsigned s;
        s = a + b;
        return (s > lim) ? lim : s;
    endfunction

endpackage

// File: rtl/otp_bit_array.sv
module otp_bit_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_bit
);
    localparam int DEPTH = 1 << ADDR_W;

    // Unprogrammed cells power up as zero; a cell can only ever be set.
    logic [DEPTH-1:0] cells = '0;

    always_ff @(posedge clk) begin
        if (prog_en) cells[addr] <= 1'b1;
    end

    // Address 0 is treated as permanently set.
    assign rd_bit = (addr == '0) | cells[addr];

endmodule

// File: rtl/usage_tick_gen.sv
module usage_tick_gen #(
    parameter int DIV_RATIO = 24_000_000,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CNT_W-1:0] session
);
    localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);

    logic [DIV_W-1:0] div_cnt;
    logic             tick;

    assign tick = run && (div_cnt == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (run) begin
            div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            session <= '0;
        end else if (tick && (session != '1)) begin
            session <= session + CNT_W'(1);
        end
    end

    p_session_step_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(session));

endmodule

// File: rtl/usage_search.sv
module usage_search
    import usage_rec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_bit,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              done,
    output logic [ADDR_W-1:0] found
);
    localparam logic [ADDR_W-1:0] TOP_MASK = ADDR_W'(1) << (ADDR_W - 1);

    srch_state_e       state;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;

    // Probe the next lower bit on top of what is known to be set.
    assign rd_addr = base | mask;
    assign done    = (state == SRCH_DONE);
    assign found   = base;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SRCH_WALK;
            base  <= '0;
            mask  <= TOP_MASK;
        end else if (state == SRCH_WALK) begin
            if (rd_bit) base <= rd_addr;
            if (mask[0]) state <= SRCH_DONE;
            mask <= mask >> 1;
        end
    end

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_probe_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        (state == SRCH_WALK) |-> $onehot0(mask) && (mask != '0));

endmodule

// File: rtl/usage_commit.sv
module usage_commit
    import usage_rec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              search_done,
    input  logic [ADDR_W-1:0] found,
    input  logic [ADDR_W-1:0] session,
    input  logic              auth,
    output logic              prog_en,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [ADDR_W-1:0] committed,
    output logic              full
);
    localparam int unsigned MAX_TOT = (1 << ADDR_W) - 1;

    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] samp_q;   // sampled adder output
    logic [ADDR_W-1:0] last_q;   // committed total, one step behind
    commit_ctl_t       ctl;
    logic              armed_q;

    assign sum = ADDR_W'(sat_sum(32'(found), 32'(session), MAX_TOT));

    always_comb begin
        ctl.armed  = armed_q;
        ctl.differ = |(samp_q ^ last_q);
        ctl.prog   = armed_q && ctl.differ && !auth;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            samp_q  <= '0;
            last_q  <= '0;
        end else if (!armed_q) begin
            if (search_done) begin
                armed_q <= 1'b1;
                samp_q  <= found;
                last_q  <= found;
            end
        end else begin
            samp_q <= sum;
            if (ctl.prog) last_q <= last_q + ADDR_W'(1);
        end
    end

    assign prog_en   = ctl.prog;
    assign prog_addr = last_q + ADDR_W'(1);
    assign committed = last_q;
    assign full      = (last_q == ADDR_W'(MAX_TOT));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> (last_q == $past(last_q)) || (last_q == $past(last_q) + ADDR_W'(1)));

    p_prog_not_ahead_r4: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> (prog_addr <= samp_q));

    p_auth_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (auth && armed_q) |=> $stable(last_q));

    p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
        full |=> full);

endmodule

// File: rtl/usage_recorder.sv
module usage_recorder #(
    parameter int DIV_RATIO = 24_000_000,
    parameter int ADDR_W    = 8,
    parameter int OUT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auth,
    input  logic [OUT_W-1:0] func_in,
    output logic [OUT_W-1:0] pin_out,
    output logic             full
);
    localparam int PAD_W = OUT_W - ADDR_W;

    logic              search_done;
    logic              rd_bit;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] found;
    logic [ADDR_W-1:0] session;
    logic              prog_en;
    logic [ADDR_W-1:0] prog_addr;
    logic [ADDR_W-1:0] committed;
    logic [ADDR_W-1:0] arr_addr;

    // Shared address port: search owns it until done, then the program path.
    assign arr_addr = search_done ? prog_addr : rd_addr;

    otp_bit_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .prog_en (prog_en),
        .addr    (arr_addr),
        .rd_bit  (rd_bit)
    );

    usage_search #(.ADDR_W(ADDR_W)) u_search (
        .clk     (clk),
        .rst     (rst),
        .rd_bit  (rd_bit),
        .rd_addr (rd_addr),
        .done    (search_done),
        .found   (found)
    );

    usage_tick_gen #(.DIV_RATIO(DIV_RATIO), .CNT_W(ADDR_W)) u_ticks (
        .clk     (clk),
        .rst     (rst),
        .run     (search_done),
        .session (session)
    );

    usage_commit #(.ADDR_W(ADDR_W)) u_commit (
        .clk         (clk),
        .rst         (rst),
        .search_done (search_done),
        .found       (found),
        .session     (session),
        .auth        (auth),
        .prog_en     (prog_en),
        .prog_addr   (prog_addr),
        .committed   (committed),
        .full        (full)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign pin_out = auth ? {{PAD_W{1'b0}}, committed} : func_in;
        end else begin : g_nopad
            assign pin_out = auth ? committed[OUT_W-1:0] : func_in;
        end
    endgenerate

    p_no_early_prog_r5: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> search_done);

endmodule

// File: tb/usage_recorder_bench.sv
module usage_recorder_bench;
    localparam int AW  = 5;
    localparam int DIV = 10;
    localparam int OW  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          auth = 1'b0;
    logic [OW-1:0] func_in = '0;
    logic [OW-1:0] pin_out;
    logic          full;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    usage_recorder #(.DIV_RATIO(DIV), .ADDR_W(AW), .OUT_W(OW)) u_usage_recorder (
        .clk(clk), .rst(rst), .auth(auth), .func_in(func_in),
        .pin_out(pin_out), .full(full)
    );

    function automatic int spt(int k);
        return AW + DIV * k + 6;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic power_cycle();
        @(negedge clk);
        rst  = 1'b1;
        auth = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic read_total(output int v);
        auth = 1'b1;
        #1;
        v = int'(pin_out);
        auth = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        power_cycle();
        wait_cyc(1);      read_total(v); check("R5 mid-search", v, 0);
        wait_cyc(AW);     read_total(v); check("R5 before arm", v, 0);
        wait_cyc(AW + 1); read_total(v); check("R1 blank total", v, 0);
        check("R1 full low", int'(full), 0);
    endtask

    task automatic t_passthru();
        func_in = 8'hA5; #1; check("R2 pass A5", int'(pin_out), 'hA5);
        func_in = 8'h3C; #1; check("R2 pass 3C", int'(pin_out), 'h3C);
        auth = 1'b1; #1;     check("R2 auth shows total", int'(pin_out), 0);
        auth = 1'b0;
    endtask

    task automatic t_count();
        int v;
        for (int k = 1; k <= 4; k++) begin
            wait_cyc(spt(k)); read_total(v); check("R3 tick count", v, k);
        end
    endtask

    task automatic t_power();
        int v;
        power_cycle();
        wait_cyc(AW);     read_total(v); check("R5 hidden until armed", v, 0);
        wait_cyc(AW + 1); read_total(v); check("R4 recovered", v, 4);
        wait_cyc(spt(2)); read_total(v); check("R8 continues", v, 6);
    endtask

    task automatic t_auth();
        int v;
        power_cycle();
        wait_cyc(spt(0)); read_total(v); check("R4 recovered", v, 6);
        auth = 1'b1;
        wait_cyc(spt(3)); #1;
        check("R6 frozen during auth", int'(pin_out), 6);
        auth = 1'b0;
        wait_cyc(spt(4)); read_total(v); check("R6 catch-up", v, 10);
        power_cycle();
        wait_cyc(AW + 1); read_total(v); check("R6 held ticks stored", v, 10);
    endtask

    task automatic t_full();
        int v;
        wait_cyc(spt(20)); read_total(v); check("R7 below top", v, 30);
        check("R7 full low", int'(full), 0);
        wait_cyc(spt(21)); read_total(v); check("R7 top", v, 31);
        check("R7 full high", int'(full), 1);
        wait_cyc(spt(24)); read_total(v); check("R7 saturated", v, 31);
        check("R7 full held", int'(full), 1);
        power_cycle();
        wait_cyc(AW + 2); read_total(v); check("R7 recovered top", v, 31);
        check("R7 full after power-up", int'(full), 1);
    endtask

    initial begin
        #(20 * 200_000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_passthru();
        t_count();
        t_power();
        t_auth();
        t_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule